// File: doc/BRIEF.md
# Stopwatch Timekeeping Core

This core keeps stopwatch time in tenths of a second and shows it on three decimal digits: tens of seconds, seconds and tenths. It runs from a fast system clock, nominally 1 MHz, but changes state only in a cycle where a one-cycle tick pulse is high. The tick arrives at 10 Hz, so one tick is one tenth of a second. The clear and start/stop events are single-cycle pulses that the button logic upstream has already aligned to the tick. The core ignores them in any other cycle.

A run flag decides whether time advances. A clear event stops the watch and zeroes it, and it wins over a start/stop event on the same tick. The digits are decimal counters chained by registered carries. A carry therefore reaches the next digit one fast cycle later. All digits have settled within three fast cycles of the tick, which is far inside the 100 000-cycle tick period. Each digit also drives an active-high seven-segment pattern.

Top module: `stopwatch_core`

## Requirements
- R1: After a clock edge with rst_n low, run_o is 0 and all three digits on bcd_o are 0.
- R2: On a tick with clr_evt high, the digits become 0 and run_o becomes 0, whatever tog_evt is.
- R3: On a tick with clr_evt low and tog_evt high, run_o inverts. On any other tick without clear, run_o keeps its value.
- R4: On a tick without clear, the time advances by one tenth if run_o was 1 before that tick, and holds otherwise. A toggle on the same tick does not affect that tick's advance.
- R5: clr_evt and tog_evt have no effect in cycles where tick is low. Run flag and digits stay unchanged.
- R6: Every digit counts 0 to 9 in decimal. A digit passing 9 returns to 0 and carries into the next digit. From 99.9 the time wraps to 00.0.
- R7: Carries ripple one fast cycle per digit. Tenths hold their new value one cycle after the tick edge, seconds after two and tens after three. Ticks must be at least three cycles apart.
- R8: bcd_o[4i+3:4i] holds digit i, and seg_o[7i+6:7i] holds its pattern, where i=0 is tenths, i=1 is seconds and i=2 is tens. Segment a is bit 6 and segment g is bit 0, active high. The patterns for digits 0 to 9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F and 7B in hex. Any other value gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle 10 Hz time step |
| clr_evt | input | 1 | Clear event, used only with tick |
| tog_evt | input | 1 | Start/stop event, used only with tick |
| run_o | output | 1 | Run flag |
| bcd_o | output | 12 | Three BCD digits, tenths in the low nibble |
| seg_o | output | 21 | Seven-segment patterns, tenths in the low seven bits |

## Verification
The bench goes after a clear and a toggle on the same tick. A design with the wrong priority would leave the watch running. It also checks a start tick from rest. A core that used the freshly toggled run flag would advance one tenth too early. The 09.9 to 10.0 carry and the 99.9 to 00.0 wrap are sampled cycle by cycle after the tick. A missing carry, a binary overflow past 9, or carries that land all at once or in the wrong cycle show up as wrong partial digits. Stray clear and toggle pulses between ticks expose a core that reacts without a tick.

// File: rtl/sw_pkg.sv
// Package: shared widths and types for the stopwatch core.
// Assumes decimal digits held in four bits and seven-segment patterns with a at the MSB.
package sw_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/sw_control.sv
// Module: run-flag controller.
// Updates the run flag only on tick; clear wins over start/stop.
// Assumes the event pulses are already aligned to tick.
module sw_control (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr_evt,
    input  logic tog_evt,
    output logic run_q
);
    // Run flag register: cleared by reset or a clearing tick, inverted by a toggle tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (tick && clr_evt)
            run_q <= 1'b0;
        else if (tick && tog_evt)
            run_q <= ~run_q;
    end

    p_clear_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_evt) |=> !run_q);
    p_toggle_inverts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_evt && tog_evt) |=> (run_q != $past(run_q)));
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(run_q));
endmodule

// File: rtl/sw_digit.sv
// Module: one decimal counter digit with a registered carry out.
// inc_i adds one; clr_i zeroes the digit and wins over inc_i.
// The carry pulses for one cycle after the digit wraps.
// Assumes inc_i is a single-cycle pulse.
module sw_digit #(
    parameter int MODULUS = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           inc_i,
    output sw_pkg::bcd_t   val_q,
    output logic           carry_q
);
    localparam sw_pkg::bcd_t LAST = sw_pkg::bcd_t'(MODULUS - 1);

    // Digit value: clear, wrap at LAST, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            val_q <= '0;
        else if (inc_i)
            val_q <= (val_q == LAST) ? '0 : val_q + 1'b1;
    end

    // Carry pulse: raised for one cycle when the digit wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            carry_q <= 1'b0;
        else
            carry_q <= inc_i && (val_q == LAST);
    end

    p_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= LAST);
    p_wrap_carries_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && val_q == LAST) |=> (carry_q && val_q == '0));
    p_digit_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(val_q));
endmodule

// File: rtl/sw_seg7.sv
// Module: BCD to seven-segment decoder, active high, segment a at bit 6 and g at bit 0.
// Values above 9 blank the display.
module sw_seg7 (
    input  sw_pkg::bcd_t digit_i,
    output sw_pkg::seg_t seg_o
);
    // Pattern lookup for one digit.
    always_comb begin
        case (digit_i)
            4'd0:    seg_o = 7'h7E;
            4'd1:    seg_o = 7'h30;
            4'd2:    seg_o = 7'h6D;
            4'd3:    seg_o = 7'h79;
            4'd4:    seg_o = 7'h33;
            4'd5:    seg_o = 7'h5B;
            4'd6:    seg_o = 7'h5F;
            4'd7:    seg_o = 7'h70;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h7B;
            default: seg_o = 7'h00;
        endcase
    end
endmodule

// File: rtl/stopwatch_core.sv
// Module: stopwatch timekeeping core (top).
// Holds a run flag and NUM_DIGITS decimal digits, with digit 0 the least significant.
// Acts only on tick. Carries ripple through registers, one fast cycle per digit.
// Assumes ticks are single-cycle pulses at least NUM_DIGITS cycles apart.
module stopwatch_core #(
    parameter int NUM_DIGITS = 3,
    parameter int MODULUS    = 10,
    localparam int BCD_W     = NUM_DIGITS * sw_pkg::DIGIT_W,
    localparam int SEGS_W    = NUM_DIGITS * sw_pkg::SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr_evt,
    input  logic              tog_evt,
    output logic              run_o,
    output logic [BCD_W-1:0]  bcd_o,
    output logic [SEGS_W-1:0] seg_o
);
    logic                  run_q;
    logic                  clr_now;
    logic [NUM_DIGITS-1:0] inc;
    logic [NUM_DIGITS-1:0] carry;

    sw_control u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr_evt (clr_evt),
        .tog_evt (tog_evt),
        .run_q   (run_q)
    );

    // Step requests: the lowest digit steps on a running tick (run flag before toggle), the others step on the carry below.
    always_comb begin
        clr_now = tick && clr_evt;
        inc     = {carry[NUM_DIGITS-2:0], tick && run_q && !clr_evt};
    end

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        sw_pkg::bcd_t val;
        sw_digit #(.MODULUS(MODULUS)) u_dig (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_now),
            .inc_i   (inc[i]),
            .val_q   (val),
            .carry_q (carry[i])
        );
        sw_seg7 u_seg (
            .digit_i (val),
            .seg_o   (seg_o[i*sw_pkg::SEG_W +: sw_pkg::SEG_W])
        );
        assign bcd_o[i*sw_pkg::DIGIT_W +: sw_pkg::DIGIT_W] = val;
    end

    assign run_o = run_q;

    p_full_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry[NUM_DIGITS-1] |-> (bcd_o == '0));
    p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[0] && !clr_evt) |=> !tick);
endmodule

// File: tb/sim_stopwatch_core.sv
// Bench: mixes directed corner cases with seeded random ticks and events,
// and compares every output against a tenths-count model.
module sim_stopwatch_core;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic clr_evt = 1'b0;
    logic tog_evt = 1'b0;
    logic run_o;
    logic [ND*4-1:0] bcd_o;
    logic [ND*7-1:0] seg_o;

    int n_checks = 0;
    int n_fail = 0;
    int exp_t = 0;
    bit exp_run = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopwatch_core u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr_evt(clr_evt),
        .tog_evt(tog_evt), .run_o(run_o), .bcd_o(bcd_o), .seg_o(seg_o)
    );

    function automatic logic [6:0] seg_of(int d);
        case (d)
            0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D; 3: return 7'h79;
            4: return 7'h33; 5: return 7'h5B; 6: return 7'h5F; 7: return 7'h70;
            8: return 7'h7F; 9: return 7'h7B; default: return 7'h00;
        endcase
    endfunction

    function automatic int digit_of(int t, int i);
        int v = t;
        for (int k = 0; k < i; k++) v = v / 10;
        return v % 10;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compares digits and patterns against a mix: digit i comes from t_new when i < upto, else from t_old.
    task automatic chk_digits(string req, int t_old, int t_new, int upto);
        for (int i = 0; i < ND; i++) begin
            int d = (i < upto) ? digit_of(t_new, i) : digit_of(t_old, i);
            chk(req, int'(bcd_o[i*4 +: 4]), d);
            chk("R8", int'(seg_o[i*7 +: 7]), int'(seg_of(d)));
        end
    endtask

    // One tick with the given events, model update, optional per-cycle ripple check, then idle cycles with stray events.
    task automatic do_tick(bit c, bit g, bit ripple, string req);
        int t_old = exp_t;
        if (c) begin
            exp_t = 0;
            exp_run = 1'b0;
        end else begin
            if (exp_run) exp_t = (exp_t + 1) % 1000;
            if (g) exp_run = !exp_run;
        end
        @(negedge clk);
        tick = 1'b1; clr_evt = c; tog_evt = g;
        for (int k = 1; k <= ND; k++) begin
            @(negedge clk);
            tick = 1'b0; clr_evt = 1'b0; tog_evt = 1'b0;
            if (ripple && k < ND) chk_digits("R7", t_old, exp_t, k);
        end
        chk_digits(req, t_old, exp_t, ND);
        chk(req, int'(run_o), int'(exp_run));
        for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
            clr_evt = ($urandom_range(0, 3) == 0);
            tog_evt = ($urandom_range(0, 3) == 0);
            @(negedge clk);
        end
        clr_evt = 1'b0; tog_evt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(run_o), 0);
        chk_digits("R1", 0, 0, ND);

        // R4: stopped tick holds
        do_tick(1'b0, 1'b0, 1'b0, "R4");
        // R4: start tick does not advance on that same tick
        do_tick(1'b0, 1'b1, 1'b0, "R4");
        chk("R4", int'(bcd_o), 0);
        // R5: stray events without tick are ignored
        @(negedge clk); clr_evt = 1'b1; tog_evt = 1'b1;
        @(negedge clk); clr_evt = 1'b0; tog_evt = 1'b0;
        @(negedge clk);
        chk("R5", int'(run_o), 1);
        chk("R5", int'(bcd_o), 0);
        // run to 09.9, then check the carry ripple into seconds (R6, R7)
        while (exp_t != 99) do_tick(1'b0, 1'b0, 1'b0, "R4");
        do_tick(1'b0, 1'b0, 1'b1, "R6");
        chk("R6", int'(bcd_o), 12'h100);
        // R2: clear and toggle on the same tick, clear wins
        do_tick(1'b1, 1'b1, 1'b0, "R2");
        chk("R2", int'(run_o), 0);
        // R3: toggle on, toggle off, no-event tick holds
        do_tick(1'b0, 1'b1, 1'b0, "R3");
        do_tick(1'b0, 1'b0, 1'b0, "R3");
        do_tick(1'b0, 1'b1, 1'b0, "R3");
        do_tick(1'b0, 1'b0, 1'b0, "R3");

        // random phase
        for (int n = 0; n < 1500; n++)
            do_tick($urandom_range(0, 19) == 0, $urandom_range(0, 9) == 0, 1'b0, "R3");

        // full wrap 99.9 -> 00.0 with ripple check through all digits (R6, R7)
        do_tick(1'b1, 1'b0, 1'b0, "R2");
        do_tick(1'b0, 1'b1, 1'b0, "R3");
        while (exp_t != 999) do_tick(1'b0, 1'b0, 1'b0, "R6");
        chk("R6", int'(bcd_o), 12'h999);
        do_tick(1'b0, 1'b0, 1'b1, "R7");
        chk("R6", int'(bcd_o), 0);
        chk("R6", int'(run_o), 1);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1", int'(run_o), 0);
        exp_t = 0; exp_run = 1'b0;
        do_tick(1'b0, 1'b0, 1'b0, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule